// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two 4x4 matrices of unsigned 8-bit operands on a grid of sixteen identical multiply-accumulate cells. Each result element lives in its own cell for the whole computation. Rows of A travel rightwards and columns of B travel downwards, moving one cell per clock over nearest-neighbour links only. Row i of A is fed to the left edge one clock after row i-1. Column j of B is fed to the top edge one clock after column j-1. Because of this skew, a_ik and b_kj meet in cell (i,j) on the same clock. All edge slots outside the skewed window carry zero.

Software loads A and B element by element through a small write port, then pulses a start strobe. The strobe clears every accumulator. The grid steps for 3*4-2 = 10 clocks and then raises a done flag. Any element of C can be read combinationally through a row/column select until the next accepted start. Accumulators are 18 bits wide, which holds the largest possible sum of four 8-bit by 8-bit products exactly.

Top module: `sys_matmul_os`

## Requirements
- R1: After reset, done_o is 0 and c_o reads 0 for every (rd_row_i, rd_col_i).
- R2: After a run, c_o at row r and column c equals the sum over k = 0..3 of A[r][k]*B[k][c]. The operands are unsigned 8-bit values and the sum is exact.
- R3: A start is accepted when start_i is high at a clock edge while the block is not busy. done_o goes high right after the tenth clock edge that follows the accepting edge. It stays high until the next accepted start.
- R4: An accepted start clears all sixteen accumulators and drops done_o at the accepting edge, so no earlier result leaks into the new one.
- R5: At a clock edge, ld_a_i high writes ld_a_data_i to A[ld_row_i][ld_col_i], where ld_row_i selects the row and ld_col_i selects the column. ld_b_i does the same for B with ld_b_data_i. Both may be written in the same cycle.
- R6: The block is busy from the accepting edge until the edge on which done_o rises. Loads while it is busy are ignored and do not change the result of the run.
- R7: A start strobe while the block is busy is ignored. The run in progress keeps its done timing and its result.
- R8: A load in the same cycle as an accepted start is written, and it takes effect in that run.
- R9: With every element of A and B equal to 255, every element of C is 260100, with no wrap.
- R10: When the block is idle, c_o follows rd_row_i and rd_col_i combinationally. The results stay unchanged, in any read order and for any time, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| ld_a_i | input | 1 | Write enable for A |
| ld_b_i | input | 1 | Write enable for B |
| ld_row_i | input | 2 | Row index for loads |
| ld_col_i | input | 2 | Column index for loads |
| ld_a_data_i | input | 8 | Data written to A |
| ld_b_data_i | input | 8 | Data written to B |
| rd_row_i | input | 2 | Row of C to read |
| rd_col_i | input | 2 | Column of C to read |
| c_o | output | 18 | Selected element of C |
| done_o | output | 1 | Run complete, result valid |

## Verification
Several functions can land on the same clock edge: a start strobe together with an operand write, a start or a write arriving in the middle of a busy run, and an A write together with a B write. The bench provokes each collision on purpose. It raises ld_a_i on the same cycle as an accepted start, and it injects a write or a second start on the third busy cycle. It also loads A and B in a single cycle throughout. Each collision is judged at the ports, by the exact edge on which done_o rises and by comparing all sixteen results with a product computed in the bench from its own copy of the matrices, with the mid-run write excluded.

// File: rtl/mm_pkg.sv
package mm_pkg;
  parameter int unsigned MM_N  = 4;
  parameter int unsigned MM_DW = 8;
  parameter int unsigned MM_AW = 18;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  // clocks needed for the last pair to reach the far corner
  function automatic int unsigned run_steps(int unsigned n);
    return 3 * n - 2;
  endfunction
endpackage

// File: rtl/mm_seq.sv
module mm_seq
  import mm_pkg::*;
#(
  parameter  int unsigned N  = MM_N,
  localparam int unsigned SW = $clog2(run_steps(N))
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          clear_o,
  output logic          run_o,
  output logic [SW-1:0] step_o,
  output logic          done_o
);
  localparam int unsigned LAST = run_steps(N) - 1;

  seq_state_e    state_q;
  logic [SW-1:0] step_q;
  logic          accept;

  assign accept = start_i && (state_q != SEQ_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      step_q  <= '0;
    end else if (accept) begin
      state_q <= SEQ_RUN;
      step_q  <= '0;
    end else if (state_q == SEQ_RUN) begin
      if (step_q == SW'(LAST)) begin
        state_q <= SEQ_DONE;
        step_q  <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign clear_o = accept;
  assign run_o   = (state_q == SEQ_RUN);
  assign step_o  = step_q;
  assign done_o  = (state_q == SEQ_DONE);
endmodule

// File: rtl/mm_store.sv
module mm_store
  import mm_pkg::*;
#(
  parameter  int unsigned N  = MM_N,
  parameter  int unsigned DW = MM_DW,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned SW = $clog2(run_steps(N))
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          run_i,
  input  logic [SW-1:0]                 step_i,
  input  logic                          ld_a_i,
  input  logic                          ld_b_i,
  input  logic [IW-1:0]                 ld_row_i,
  input  logic [IW-1:0]                 ld_col_i,
  input  logic [DW-1:0]                 ld_a_data_i,
  input  logic [DW-1:0]                 ld_b_data_i,
  output logic [N-1:0][DW-1:0]          a_edge_o,
  output logic [N-1:0][DW-1:0]          b_edge_o,
  output logic [N-1:0][N-1:0][DW-1:0]   a_st_o,
  output logic [N-1:0][N-1:0][DW-1:0]   b_st_o
);
  logic [N-1:0][N-1:0][DW-1:0] a_m, b_m;

  // operands are frozen while the grid is stepping
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_m <= '0;
      b_m <= '0;
    end else if (!run_i) begin
      if (ld_a_i) a_m[ld_row_i][ld_col_i] <= ld_a_data_i;
      if (ld_b_i) b_m[ld_row_i][ld_col_i] <= ld_b_data_i;
    end
  end

  assign a_st_o = a_m;
  assign b_st_o = b_m;

  // skewed edge feed: lane l carries element (step - l), zero outside the window
  for (genvar l = 0; l < int'(N); l++) begin : g_lane
    int k;
    always_comb begin
      k = int'(step_i) - l;
      a_edge_o[l] = '0;
      b_edge_o[l] = '0;
      if (run_i && k >= 0 && k < int'(N)) begin
        a_edge_o[l] = a_m[l][k[IW-1:0]];
        b_edge_o[l] = b_m[k[IW-1:0]][l];
      end
    end
  end
endmodule

// File: rtl/mm_pe.sv
module mm_pe
  import mm_pkg::*;
#(
  parameter int unsigned DW = MM_DW,
  parameter int unsigned AW = MM_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [AW-1:0] acc_o
);
  logic [2*DW-1:0] prod;
  logic [AW-1:0]   acc_q;

  assign prod = a_i * b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (run_i)   acc_q <= acc_q + AW'(prod);
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mm_grid.sv
module mm_grid
  import mm_pkg::*;
#(
  parameter int unsigned N  = MM_N,
  parameter int unsigned DW = MM_DW,
  parameter int unsigned AW = MM_AW
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic                        run_i,
  input  logic [N-1:0][DW-1:0]        a_edge_i,
  input  logic [N-1:0][DW-1:0]        b_edge_i,
  output logic [N-1:0][N-1:0][AW-1:0] acc_o
);
  logic [DW-1:0] a_in [N][N];
  logic [DW-1:0] b_in [N][N];

  for (genvar i = 0; i < int'(N); i++) begin : g_r
    for (genvar j = 0; j < int'(N); j++) begin : g_c
      // horizontal hop into this cell
      if (j == 0) begin : g_a_edge
        assign a_in[i][j] = a_edge_i[i];
      end else begin : g_a_hop
        logic [DW-1:0] hop_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)      hop_q <= '0;
          else if (clear_i) hop_q <= '0;
          else if (run_i)   hop_q <= a_in[i][j-1];
        end
        assign a_in[i][j] = hop_q;
      end

      // vertical hop into this cell
      if (i == 0) begin : g_b_edge
        assign b_in[i][j] = b_edge_i[j];
      end else begin : g_b_hop
        logic [DW-1:0] hop_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)      hop_q <= '0;
          else if (clear_i) hop_q <= '0;
          else if (run_i)   hop_q <= b_in[i-1][j];
        end
        assign b_in[i][j] = hop_q;
      end

      mm_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clear_i(clear_i),
        .run_i  (run_i),
        .a_i    (a_in[i][j]),
        .b_i    (b_in[i][j]),
        .acc_o  (acc_o[i][j])
      );
    end
  end
endmodule

// File: rtl/sys_matmul_os.sv
module sys_matmul_os
  import mm_pkg::*;
#(
  parameter  int unsigned N  = MM_N,
  parameter  int unsigned DW = MM_DW,
  parameter  int unsigned AW = MM_AW,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned SW = $clog2(run_steps(N))
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ld_a_i,
  input  logic          ld_b_i,
  input  logic [IW-1:0] ld_row_i,
  input  logic [IW-1:0] ld_col_i,
  input  logic [DW-1:0] ld_a_data_i,
  input  logic [DW-1:0] ld_b_data_i,
  input  logic [IW-1:0] rd_row_i,
  input  logic [IW-1:0] rd_col_i,
  output logic [AW-1:0] c_o,
  output logic          done_o
);
  logic                        clear_w;
  logic                        run_w;
  logic [SW-1:0]               step_w;
  logic [N-1:0][DW-1:0]        a_edge_w, b_edge_w;
  logic [N-1:0][N-1:0][DW-1:0] a_st_w, b_st_w;
  logic [N-1:0][N-1:0][AW-1:0] acc_w;

  mm_seq #(.N(N)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .clear_o(clear_w),
    .run_o  (run_w),
    .step_o (step_w),
    .done_o (done_o)
  );

  mm_store #(.N(N), .DW(DW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_w),
    .step_i     (step_w),
    .ld_a_i     (ld_a_i),
    .ld_b_i     (ld_b_i),
    .ld_row_i   (ld_row_i),
    .ld_col_i   (ld_col_i),
    .ld_a_data_i(ld_a_data_i),
    .ld_b_data_i(ld_b_data_i),
    .a_edge_o   (a_edge_w),
    .b_edge_o   (b_edge_w),
    .a_st_o     (a_st_w),
    .b_st_o     (b_st_w)
  );

  mm_grid #(.N(N), .DW(DW), .AW(AW)) u_grid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_w),
    .run_i   (run_w),
    .a_edge_i(a_edge_w),
    .b_edge_i(b_edge_w),
    .acc_o   (acc_w)
  );

  assign c_o = acc_w[rd_row_i][rd_col_i];
endmodule

// File: rtl/sys_matmul_os_chk.sv
module sys_matmul_os_chk
  import mm_pkg::*;
#(
  parameter int unsigned N  = MM_N,
  parameter int unsigned DW = MM_DW,
  parameter int unsigned AW = MM_AW
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                ld_a_i,
  input logic                ld_b_i,
  input logic                done_o,
  input logic                run_i,
  input logic [N*N*AW-1:0]   acc_i,
  input logic [N*N*DW-1:0]   a_st_i,
  input logic [N*N*DW-1:0]   b_st_i
);
  localparam int unsigned SPAN = run_steps(N);
  localparam int unsigned CW   = $clog2(SPAN) + 2;

  logic [CW-1:0] since_q;

  // clocks elapsed since the last accepted start, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_q <= '1;
    else if (start_i && !run_i)   since_q <= '0;
    else if (since_q != '1)       since_q <= since_q + 1'b1;
  end

  // R3
  done_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (since_q == CW'(SPAN)));

  // R3
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  // R4
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !run_i) |=> (acc_i == '0 && !done_o));

  // R6
  busy_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (ld_a_i || ld_b_i)) |=> ($stable(a_st_i) && $stable(b_st_i)));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> $stable(acc_i));
endmodule

bind sys_matmul_os sys_matmul_os_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .ld_a_i (ld_a_i),
  .ld_b_i (ld_b_i),
  .done_o (done_o),
  .run_i  (run_w),
  .acc_i  (acc_w),
  .a_st_i (a_st_w),
  .b_st_i (b_st_w)
);

// File: tb/sys_matmul_os_bench.sv
module sys_matmul_os_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ld_a = 1'b0, ld_b = 1'b0;
  logic [1:0]  ld_row = '0, ld_col = '0;
  logic [7:0]  ld_ad = '0, ld_bd = '0;
  logic [1:0]  rd_row = '0, rd_col = '0;
  logic [17:0] c;
  logic        done;

  int nchk = 0;
  int nerr = 0;
  int ma [N][N];
  int mb [N][N];

  always #2.5 clk = ~clk;

  sys_matmul_os u_sys_matmul_os (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .ld_a_i     (ld_a),
    .ld_b_i     (ld_b),
    .ld_row_i   (ld_row),
    .ld_col_i   (ld_col),
    .ld_a_data_i(ld_ad),
    .ld_b_data_i(ld_bd),
    .rd_row_i   (rd_row),
    .rd_col_i   (rd_col),
    .c_o        (c),
    .done_o     (done)
  );

  task automatic check_eq(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_c(int r, int col);
    int s = 0;
    for (int k = 0; k < N; k++) s += ma[r][k] * mb[k][col];
    return s;
  endfunction

  // R5: A and B written together, same index
  task automatic load_mats();
    for (int r = 0; r < N; r++)
      for (int col = 0; col < N; col++) begin
        @(negedge clk);
        ld_a = 1'b1; ld_b = 1'b1;
        ld_row = 2'(r); ld_col = 2'(col);
        ld_ad = 8'(ma[r][col]); ld_bd = 8'(mb[r][col]);
      end
    @(negedge clk);
    ld_a = 1'b0; ld_b = 1'b0;
  endtask

  // mode 0 plain, 1 load while busy, 2 start while busy, 3 load with start
  task automatic run(int mode, string req);
    @(negedge clk);
    start = 1'b1;
    if (mode == 3) begin
      ld_a = 1'b1; ld_row = 2'd1; ld_col = 2'd2; ld_ad = 8'(ma[1][2]);
    end
    @(negedge clk);
    start = 1'b0; ld_a = 1'b0;
    check_eq({req, " R4 done low after start"}, int'(done), 0);
    for (int cyc = 1; cyc <= 10; cyc++) begin
      @(negedge clk);
      start = 1'b0; ld_a = 1'b0;
      check_eq($sformatf("%s R3 done at cycle %0d", req, cyc), int'(done), (cyc < 10) ? 0 : 1);
      if (cyc == 3 && mode == 1) begin
        ld_a = 1'b1; ld_row = 2'd0; ld_col = 2'd0; ld_ad = 8'(ma[0][0] ^ 8'h5a);
      end
      if (cyc == 3 && mode == 2) start = 1'b1;
    end
  endtask

  task automatic check_results(string req, bit reverse);
    for (int n = 0; n < N * N; n++) begin
      int idx = reverse ? (N * N - 1 - n) : n;
      rd_row = 2'(idx / N); rd_col = 2'(idx % N);
      #0.5;
      check_eq($sformatf("%s c[%0d][%0d]", req, idx / N, idx % N), int'(c), ref_c(idx / N, idx % N));
    end
  endtask

  task automatic rand_mats();
    for (int r = 0; r < N; r++)
      for (int col = 0; col < N; col++) begin
        ma[r][col] = int'($urandom_range(0, 255));
        mb[r][col] = int'($urandom_range(0, 255));
      end
  endtask

  task automatic t_reset();
    check_eq("R1 done after reset", int'(done), 0);
    for (int r = 0; r < N; r++) for (int col = 0; col < N; col++) begin ma[r][col] = 0; mb[r][col] = 0; end
    check_results("R1 reset", 1'b0);
  endtask

  task automatic t_random();
    for (int rnd = 0; rnd < 4; rnd++) begin
      rand_mats();
      load_mats();
      run(0, "R2");
      check_results("R2 R5 random", 1'b0);
    end
  endtask

  task automatic t_full();
    for (int r = 0; r < N; r++) for (int col = 0; col < N; col++) begin ma[r][col] = 255; mb[r][col] = 255; end
    load_mats();
    run(0, "R9");
    check_results("R9 full scale", 1'b0);
    check_eq("R9 value", int'(c), 260100);
  endtask

  task automatic t_clear();
    for (int r = 0; r < N; r++) for (int col = 0; col < N; col++) ma[r][col] = 0;
    load_mats();
    run(0, "R4");
    check_results("R4 cleared", 1'b0);
  endtask

  task automatic t_busy_load();
    rand_mats();
    load_mats();
    run(1, "R6");
    check_results("R6 busy load ignored", 1'b0);
    // store must still hold the old A[0][0]: rerun and compare
    run(0, "R6 rerun");
    check_results("R6 store unchanged", 1'b0);
  endtask

  task automatic t_busy_start();
    rand_mats();
    load_mats();
    run(2, "R7");
    check_results("R7 busy start ignored", 1'b0);
  endtask

  task automatic t_load_on_start();
    rand_mats();
    load_mats();
    ma[1][2] = (ma[1][2] + 77) % 256;
    run(3, "R8");
    check_results("R8 load with start", 1'b0);
  endtask

  task automatic t_hold();
    repeat (20) @(negedge clk);
    check_eq("R3 done stays high", int'(done), 1);
    check_results("R10 hold reverse", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_random();
    t_full();
    t_clear();
    t_busy_load();
    t_busy_start();
    t_load_on_start();
    t_hold();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule